// File: doc/BRIEF.md
# Multi-Mode Addressable Latch and One-Hot Demultiplexer

This block holds eight single-bit outputs that are selected by a 3-bit binary index. Two active-low controls, a write enable and a clear, pick one of four behaviours each clock cycle. It can write one bit in place while keeping the others, hold everything, steer the data bit to one output while zeroing the rest, or zero every output. A single register bank serves all four behaviours, so one instance can act as a bit-addressable flag register or as a one-hot strobe generator.

Everything is synchronous to the rising clock edge, and every output comes straight from a flip-flop. A separate synchronous active-high reset zeroes the bank on power-up. In demultiplex and clear modes, the register contents themselves are overwritten, so a later hold keeps the last pattern that was driven. When consecutive cycles are both write-mode cycles, the address may change in at most one bit between them. Wider changes of the address belong in hold cycles.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` becomes 0 on that edge.
- R2: When `wr_n`=0 and `clr_n`=1 (write mode), the edge loads `din` into `q[sel]`, where `sel` is a binary index (value k selects bit k).
- R3: In write mode, every bit of `q` other than `q[sel]` keeps its value across the edge.
- R4: When `wr_n`=1 and `clr_n`=1 (hold mode), `q` does not change, whatever `sel` and `din` do.
- R5: When `wr_n`=0 and `clr_n`=0 (demultiplex mode), the edge sets `q[sel]` to `din` and every other bit to 0, so at most one bit is set.
- R6: When `wr_n`=1 and `clr_n`=0 (clear mode), the edge sets every bit of `q` to 0, whatever `sel` and `din` are.
- R7: After a demultiplex-mode or clear-mode cycle, the following hold-mode cycles keep exactly the pattern that the last such cycle produced.
- R8: Between two consecutive write-mode cycles, `sel` changes in at most one bit. A walk of the address in single-bit steps writes each location it visits.
- R9: `rst` has priority over all four modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low enable: write or demultiplex when low |
| clr_n | input | 1 | Active-low clear: demultiplex or clear when low |
| sel | input | 3 | Binary index of the target bit |
| din | input | 1 | Data bit |
| q | output | 8 | Registered outputs |

## Verification
Demultiplex mode writes the addressed bit and clears all the others in the same edge, so a fault in either half shows up as a wrong one-hot word. Clear mode and the system reset both zero the bank, and the reset must win even when a write or demultiplex request arrives on the same edge. Random mode sequences, mixed with directed cases, produce demultiplex cycles on top of a bank that already has bits set, and a reset that coincides with an active write. A bench model predicts the full eight-bit word after each edge, and the bench compares it with `q`.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alm_mode_t;
endpackage

// File: rtl/alm_mode_dec.sv
module alm_mode_dec
  import addr_latch_pkg::*;
(
  input  logic      wr_n,
  input  logic      clr_n,
  output alm_mode_t mode
);
  always_comb begin
    unique case ({clr_n, wr_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alm_onehot.sv
module alm_onehot #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [N_OUT-1:0]  hit
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_hit
    assign hit[i] = (sel == ADDR_W'(i));
  end
endmodule

// File: rtl/alm_cell.sv
module alm_cell
  import addr_latch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  alm_mode_t mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_WRITE: if (hit) q <= din;
        MODE_HOLD:  q <= q;
        MODE_DEMUX: q <= hit & din;
        MODE_CLEAR: q <= 1'b0;
        default:    q <= q;
      endcase
    end
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [N_OUT-1:0]  q
);
  alm_mode_t         mode;
  logic [N_OUT-1:0]  hit;

  alm_mode_dec u_mode (.wr_n(wr_n), .clr_n(clr_n), .mode(mode));

  alm_onehot #(.ADDR_W(ADDR_W)) u_hit (.sel(sel), .hit(hit));

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    alm_cell u_cell (
      .clk(clk), .rst(rst), .mode(mode), .hit(hit[i]), .din(din), .q(q[i])
    );
  end

  // R1 R9
  reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R2
  write_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && clr_n) |=> (q[$past(sel)] == $past(din)));

  // R3
  write_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && clr_n) |=> (((q ^ $past(q)) & ~$past(hit)) == '0));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_n && clr_n) |=> $stable(q));

  // R5
  demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !clr_n) |=> ($countones(q) <= 1 && q[$past(sel)] == $past(din)));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_n && !clr_n) |=> (q == '0));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && clr_n && $past(!wr_n && clr_n) && !$past(rst))
      |-> ($countones(sel ^ $past(sel)) <= 1));
endmodule

// File: tb/addr_latch_demux_bench.sv
`timescale 1ns/1ps
module addr_latch_demux_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_n, clr_n, din;
  logic [2:0] sel;
  logic [7:0] q;
  logic [7:0] model;
  int         n_run = 0;
  int         n_fail = 0;
  bit         prev_wr;

  always #2.5 clk = ~clk;

  addr_latch_demux u_addr_latch_demux (
    .clk(clk), .rst(rst), .wr_n(wr_n), .clr_n(clr_n),
    .sel(sel), .din(din), .q(q)
  );

  function automatic logic [7:0] predict(logic [7:0] cur, logic r, logic w_n,
                                         logic c_n, logic [2:0] a, logic d);
    logic [7:0] nxt;
    nxt = cur;
    if (r) nxt = '0;
    else if (!w_n && c_n) nxt[a] = d;
    else if (!w_n && !c_n) begin nxt = '0; nxt[a] = d; end
    else if (w_n && !c_n) nxt = '0;
    return nxt;
  endfunction

  task automatic check(string req, logic [7:0] exp);
    n_run++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  task automatic step(logic r, logic w_n, logic c_n, logic [2:0] a, logic d,
                      string req);
    @(negedge clk);
    rst = r; wr_n = w_n; clr_n = c_n; sel = a; din = d;
    @(posedge clk);
    #1;
    model = predict(model, r, w_n, c_n, a, d);
    check(req, model);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: q=%b expected completion", q);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_n = 1'b1; clr_n = 1'b1; sel = '0; din = 1'b0;
    model = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 8'h00);

    // R2: write ones in a single-bit address walk (gray order), R8
    step(1'b0, 1'b1, 1'b1, 3'd0, 1'b0, "R4 idle");
    begin
      logic [2:0] gray [8] = '{3'd0, 3'd1, 3'd3, 3'd2, 3'd6, 3'd7, 3'd5, 3'd4};
      for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 1'b1, gray[k], 1'b1, "R8 R2 gray walk");
    end
    check("R2 all written", 8'hFF);
    // R3: clear bit 4 only
    step(1'b0, 1'b0, 1'b1, 3'd4, 1'b0, "R3 keep others");
    check("R3 pattern", 8'hEF);
    // R4: hold with wide address and data swings
    step(1'b0, 1'b1, 1'b1, 3'd3, 1'b0, "R4 hold");
    step(1'b0, 1'b1, 1'b1, 3'd4, 1'b1, "R4 hold");
    check("R4 unchanged", 8'hEF);
    // R5: demux over a full bank
    step(1'b0, 1'b0, 1'b0, 3'd6, 1'b1, "R5 demux one");
    check("R5 one-hot", 8'h40);
    step(1'b0, 1'b1, 1'b1, 3'd1, 1'b0, "R7 hold after demux");
    step(1'b0, 1'b1, 1'b1, 3'd2, 1'b1, "R7 hold after demux");
    check("R7 retained", 8'h40);
    step(1'b0, 1'b0, 1'b0, 3'd2, 1'b0, "R5 demux zero");
    check("R5 all low", 8'h00);
    // R6: clear after loading bits
    step(1'b0, 1'b1, 1'b1, 3'd7, 1'b1, "R4 hold");
    step(1'b0, 1'b0, 1'b1, 3'd7, 1'b1, "R2 write 7");
    step(1'b0, 1'b0, 1'b1, 3'd5, 1'b1, "R2 write 5");
    step(1'b0, 1'b1, 1'b0, 3'd5, 1'b1, "R6 clear");
    check("R6 zero", 8'h00);
    step(1'b0, 1'b1, 1'b1, 3'd0, 1'b1, "R7 hold after clear");
    // R9: reset wins over write and demux
    step(1'b0, 1'b0, 1'b1, 3'd0, 1'b1, "R2 write 0");
    step(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, "R9 reset beats write");
    check("R9 zero", 8'h00);
    step(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, "R9 reset beats demux");
    step(1'b0, 1'b1, 1'b1, 3'd3, 1'b1, "R1 after reset");

    prev_wr = 1'b0;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      logic [2:0] a;
      m = 2'($urandom % 4);
      a = sel;
      if (m == 2'd0 && prev_wr) begin
        if ($urandom % 2) a = a ^ (3'd1 << ($urandom % 3));
      end else begin
        a = 3'($urandom % 8);
      end
      unique case (m)
        2'd0: step(1'b0, 1'b0, 1'b1, a, 1'($urandom), "R2 R3 random write");
        2'd1: step(1'b0, 1'b1, 1'b1, a, 1'($urandom), "R4 random hold");
        2'd2: step(1'b0, 1'b0, 1'b0, a, 1'($urandom), "R5 random demux");
        default: step(1'b0, 1'b1, 1'b0, a, 1'($urandom), "R6 random clear");
      endcase
      prev_wr = (m == 2'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule